// File: doc/BRIEF.md
# 8-bit ALU with status flags

An 8-bit arithmetic and logic unit for a small accumulator-style processor core. Each cycle it combines a working-register value with a file operand, or with an immediate placed on the same input. It produces an 8-bit result and candidate values for the zero, digit-carry and carry flags. It also produces one update strobe per flag, so every operation changes only the flags it is defined to change. The strobes load a three-bit status register inside the block. The registered carry is the carry input for every operation that consumes one.

Subtraction is done with the first operand inverted and an initial carry of one, so a set carry after a subtract means no borrow occurred. Choosing the destination of the result and accessing the register file are left to the surrounding datapath. The block exposes the combinational result and the registered flags.

Top module: `alu8_core`

## Requirements
- R1: While and after reset, the registered zero, digit-carry and carry flags read 0.
- R2: Code 0 gives W+F. Code 1 gives W+F+C, where C is the registered carry. Both update all three flags. C is the carry out of bit 7 and DC is the carry out of bit 3 of that same sum.
- R3: Code 2 gives ~W+F+1. Code 3 gives ~W+F+C, with no added one. Both update all three flags. C=1 means no borrow.
- R4: Code 4 increments F and code 5 decrements F, modulo 256. Only Z is updated.
- R5: Codes 6, 7 and 8 give W AND F, W OR F and W XOR F. Code 9 gives ~F and code 18 passes F through unchanged. All five update only Z.
- R6: Code 10 sets and code 11 clears bit `bit_sel` of F. No flag changes.
- R7: Code 12 rotates {C,F} left by one as a 9-bit value. Code 13 rotates {F,C} right by one. Only C changes, and it takes the bit rotated out.
- R8: Code 14 shifts F right with bit 7 copied into bit 7. Code 15 shifts F left with a 0 fed in. Code 16 shifts F right with a 0 fed in. Each updates Z and C, and C takes the bit shifted out.
- R9: Code 17 exchanges bits 3:0 with bits 7:4 of F. No flag changes.
- R10: A flag register loads its candidate value at a rising edge only when `op_valid` is high and that flag's strobe is set. With `op_valid` low, all strobes are 0 and the flags hold. Codes 19 to 31 pass F to the result and assert no strobe.
- R11: For every operation that updates Z, Z becomes 1 exactly when the 8-bit result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| op_valid | input | 1 | Operation issued this cycle; allows flag updates |
| op_code | input | 5 | Operation code (see requirements) |
| w_opnd | input | 8 | Working-register operand |
| f_opnd | input | 8 | File operand or immediate |
| bit_sel | input | 3 | Bit index for bit set and bit clear |
| result | output | 8 | Combinational result |
| z_next | output | 1 | Candidate zero flag |
| dc_next | output | 1 | Candidate digit-carry flag |
| c_next | output | 1 | Candidate carry flag |
| z_upd | output | 1 | Zero flag load strobe |
| dc_upd | output | 1 | Digit-carry flag load strobe |
| c_upd | output | 1 | Carry flag load strobe |
| z_flag | output | 1 | Registered zero flag |
| dc_flag | output | 1 | Registered digit-carry flag |
| c_flag | output | 1 | Registered carry flag |

## Verification
In a carry-consuming operation, two things happen in the same cycle: the carry register is read, and the same edge overwrites it. This covers add-with-carry, subtract-with-borrow and the rotates. The bench provokes the overlap by issuing these operations back to back, so that each one both uses the carry left by the previous one and replaces it. The scoreboard keeps its own copy of the three flags. It checks each result against the carry the bench model holds before the edge, and checks the registered flags one cycle later against the model after the update. A stale or early carry therefore shows up as a mismatch in either the result or the flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 5;
  localparam int NFLAG = 3;
  localparam int FZ = 2;
  localparam int FDC = 1;
  localparam int FC = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBB = 5'd3,
    OP_INC  = 5'd4,  OP_DEC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_BSET = 5'd10, OP_BCLR = 5'd11,
    OP_RLC  = 5'd12, OP_RRC  = 5'd13, OP_ASR  = 5'd14, OP_LSL  = 5'd15,
    OP_LSR  = 5'd16, OP_SWAP = 5'd17, OP_MOV  = 5'd18
  } alu_op_e;

  typedef enum logic [2:0] {
    FCL_NONE, FCL_Z, FCL_C, FCL_ZC, FCL_ALL
  } flag_class_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             c_half,
  output logic             c_out
);
  localparam int HALF = WIDTH / 2;
  localparam int UPPER = WIDTH - HALF;

  logic [HALF:0]  lo_sum;
  logic [UPPER:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, ci};
    hi_sum = {1'b0, a[WIDTH-1:HALF]} + {1'b0, b[WIDTH-1:HALF]}
           + {{UPPER{1'b0}}, lo_sum[HALF]};
    sum    = {hi_sum[UPPER-1:0], lo_sum[HALF-1:0]};
    c_half = lo_sum[HALF];
    c_out  = hi_sum[UPPER];
  end
endmodule

// File: rtl/alu8_bitunit.sv
module alu8_bitunit
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OPW-1:0]           op,
  input  logic [WIDTH-1:0]         w,
  input  logic [WIDTH-1:0]         f,
  input  logic [$clog2(WIDTH)-1:0] idx,
  input  logic                     c_in,
  output logic [WIDTH-1:0]         res,
  output logic                     shift_out
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] onehot;

  always_comb begin
    onehot    = {{(WIDTH-1){1'b0}}, 1'b1} << idx;
    res       = f;
    shift_out = 1'b0;
    case (op)
      OP_AND:  res = w & f;
      OP_OR:   res = w | f;
      OP_XOR:  res = w ^ f;
      OP_COM:  res = ~f;
      OP_BSET: res = f | onehot;
      OP_BCLR: res = f & ~onehot;
      OP_RLC:  begin res = {f[WIDTH-2:0], c_in};    shift_out = f[WIDTH-1]; end
      OP_RRC:  begin res = {c_in, f[WIDTH-1:1]};    shift_out = f[0];       end
      OP_ASR:  begin res = {f[WIDTH-1], f[WIDTH-1:1]}; shift_out = f[0];    end
      OP_LSL:  begin res = {f[WIDTH-2:0], 1'b0};    shift_out = f[WIDTH-1]; end
      OP_LSR:  begin res = {1'b0, f[WIDTH-1:1]};    shift_out = f[0];       end
      OP_SWAP: res = {f[HALF-1:0], f[WIDTH-1:HALF]};
      default: res = f;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] upd,
  input  logic [NF-1:0] nxt,
  output logic [NF-1:0] q
);
  logic [NF-1:0] q_d;

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      q_d[i] = upd[i] ? nxt[i] : q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (|upd) begin
      q <= q_d;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_chk
    // R10: a flag without its strobe keeps its value across the edge
    assert_hold_unstrobed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd[g] |=> $stable(q[g]));
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [OPW-1:0]           op_code,
  input  logic [WIDTH-1:0]         w_opnd,
  input  logic [WIDTH-1:0]         f_opnd,
  input  logic [$clog2(WIDTH)-1:0] bit_sel,
  output logic [WIDTH-1:0]         result,
  output logic                     z_next,
  output logic                     dc_next,
  output logic                     c_next,
  output logic                     z_upd,
  output logic                     dc_upd,
  output logic                     c_upd,
  output logic                     z_flag,
  output logic                     dc_flag,
  output logic                     c_flag
);
  logic [WIDTH-1:0] add_a, add_b, add_sum, bit_res;
  logic             add_ci, add_c_half, add_c_out, use_add, bit_out;
  flag_class_e      fcls;
  logic [NFLAG-1:0] upd_v, nxt_v, flag_q;

  assign z_flag  = flag_q[FZ];
  assign dc_flag = flag_q[FDC];
  assign c_flag  = flag_q[FC];

  always_comb begin
    add_a   = w_opnd;
    add_b   = f_opnd;
    add_ci  = 1'b0;
    use_add = 1'b0;
    fcls    = FCL_NONE;
    case (op_code)
      OP_ADD:  begin use_add = 1'b1; fcls = FCL_ALL; end
      OP_ADDC: begin use_add = 1'b1; fcls = FCL_ALL; add_ci = c_flag; end
      OP_SUB:  begin use_add = 1'b1; fcls = FCL_ALL; add_a = ~w_opnd; add_ci = 1'b1; end
      OP_SUBB: begin use_add = 1'b1; fcls = FCL_ALL; add_a = ~w_opnd; add_ci = c_flag; end
      OP_INC:  begin use_add = 1'b1; fcls = FCL_Z; add_a = f_opnd; add_b = '0; add_ci = 1'b1; end
      OP_DEC:  begin use_add = 1'b1; fcls = FCL_Z; add_a = f_opnd; add_b = '1; end
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_MOV: fcls = FCL_Z;
      OP_RLC, OP_RRC:                        fcls = FCL_C;
      OP_ASR, OP_LSL, OP_LSR:                fcls = FCL_ZC;
      default:                               fcls = FCL_NONE;
    endcase
  end

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(add_a), .b(add_b), .ci(add_ci),
    .sum(add_sum), .c_half(add_c_half), .c_out(add_c_out)
  );

  alu8_bitunit #(.WIDTH(WIDTH)) u_bitunit (
    .op(op_code), .w(w_opnd), .f(f_opnd), .idx(bit_sel), .c_in(c_flag),
    .res(bit_res), .shift_out(bit_out)
  );

  always_comb begin
    result  = use_add ? add_sum : bit_res;
    z_next  = ~|result;
    dc_next = add_c_half;
    c_next  = use_add ? add_c_out : bit_out;
    z_upd   = op_valid && (fcls == FCL_Z || fcls == FCL_ZC || fcls == FCL_ALL);
    dc_upd  = op_valid && (fcls == FCL_ALL);
    c_upd   = op_valid && (fcls == FCL_C || fcls == FCL_ZC || fcls == FCL_ALL);
    upd_v   = {z_upd, dc_upd, c_upd};
    nxt_v   = {z_next, dc_next, c_next};
  end

  alu8_status #(.NF(NFLAG)) u_status (
    .clk(clk), .rst_n(rst_n), .upd(upd_v), .nxt(nxt_v), .q(flag_q)
  );

  // R1: flags come out of reset cleared
  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (flag_q == '0);
  end

  assert_add_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_ADD && w_opnd == '0) |-> (result == f_opnd && !c_next && !dc_next));

  assert_sub_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SUB && w_opnd == f_opnd) |-> (result == '0 && c_next && dc_next));

  assert_incdec_zonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> ($stable(dc_flag) && $stable(c_flag)));

  assert_logic_zonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR ||
                  op_code == OP_COM || op_code == OP_MOV))
    |=> ($stable(dc_flag) && $stable(c_flag)));

  assert_bitop_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_BSET || op_code == OP_BCLR)) |=> $stable(flag_q));

  assert_rotate_conly_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_RLC || op_code == OP_RRC)) |=> ($stable(z_flag) && $stable(dc_flag)));

  assert_shift_keep_dc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_ASR || op_code == OP_LSL || op_code == OP_LSR)) |=> $stable(dc_flag));

  assert_swap_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SWAP) |=> $stable(flag_q));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flag_q));

  assert_zero_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
    z_upd |=> (z_flag == ($past(result) == '0)));
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  typedef struct packed {
    logic [7:0] res;
    logic [2:0] nx;
    logic [2:0] we;
    logic [2:0] q;
  } exp_t;

  logic       clk, rst_n, op_valid;
  logic [4:0] op_code;
  logic [7:0] w_opnd, f_opnd, result;
  logic [2:0] bit_sel;
  logic       z_next, dc_next, c_next, z_upd, dc_upd, c_upd, z_flag, dc_flag, c_flag;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [2:0] flags_m;
  int checks, errors;
  bit done;

  alu8_core u_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .w_opnd(w_opnd), .f_opnd(f_opnd), .bit_sel(bit_sel), .result(result),
    .z_next(z_next), .dc_next(dc_next), .c_next(c_next),
    .z_upd(z_upd), .dc_upd(dc_upd), .c_upd(c_upd),
    .z_flag(z_flag), .dc_flag(dc_flag), .c_flag(c_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic exp_t model(input logic [4:0] op, input logic [7:0] w, f,
                                 input logic [2:0] idx, input logic v, input logic [2:0] fl);
    exp_t e;
    logic [8:0] s;
    logic [4:0] h;
    logic [7:0] r;
    logic co, dcv;
    logic [2:0] we;
    s = '0; h = '0; r = f; co = 1'b0; dcv = 1'b0; we = 3'b000;
    case (op)
      5'd0, 5'd1, 5'd2, 5'd3: begin
        if (op < 5'd2) begin
          s = {1'b0, w} + {1'b0, f};
          h = {1'b0, w[3:0]} + {1'b0, f[3:0]};
        end else begin
          s = {1'b0, ~w} + {1'b0, f};
          h = {1'b0, ~w[3:0]} + {1'b0, f[3:0]};
        end
        if (op == 5'd2) begin s = s + 9'd1; h = h + 5'd1; end
        if (op == 5'd1 || op == 5'd3) begin s = s + {8'd0, fl[0]}; h = h + {4'd0, fl[0]}; end
        r = s[7:0]; co = s[8]; dcv = h[4]; we = 3'b111;
      end
      5'd4:  begin r = f + 8'd1; we = 3'b100; end
      5'd5:  begin r = f - 8'd1; we = 3'b100; end
      5'd6:  begin r = w & f; we = 3'b100; end
      5'd7:  begin r = w | f; we = 3'b100; end
      5'd8:  begin r = w ^ f; we = 3'b100; end
      5'd9:  begin r = ~f;    we = 3'b100; end
      5'd18: begin r = f;     we = 3'b100; end
      5'd10: r[idx] = 1'b1;
      5'd11: r[idx] = 1'b0;
      5'd12: begin r = {f[6:0], fl[0]}; co = f[7]; we = 3'b001; end
      5'd13: begin r = {fl[0], f[7:1]}; co = f[0]; we = 3'b001; end
      5'd14: begin r = {f[7], f[7:1]};  co = f[0]; we = 3'b101; end
      5'd15: begin r = {f[6:0], 1'b0};  co = f[7]; we = 3'b101; end
      5'd16: begin r = {1'b0, f[7:1]};  co = f[0]; we = 3'b101; end
      5'd17: r = {f[3:0], f[7:4]};
      default: r = f;
    endcase
    if (!v) we = 3'b000;
    e.res = r; e.nx = {(r == 8'd0), dcv, co}; e.we = we; e.q = fl;
    return e;
  endfunction

  task automatic drive(input logic v, input logic [4:0] op, input logic [7:0] w, f,
                       input logic [2:0] idx, input string tag);
    exp_t e;
    @(negedge clk);
    op_valid = v; op_code = op; w_opnd = w; f_opnd = f; bit_sel = idx;
    e = model(op, w, f, idx, v, flags_m);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int i = 0; i < 3; i++) if (e.we[i]) flags_m[i] = e.nx[i];
  endtask

  task automatic cmp(input string tag, input string what, input logic [7:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp_v);
    end
  endtask

  // Monitor: pops one expected item per issued cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "result", result, e.res);
        cmp(t, "strobes", {5'd0, z_upd, dc_upd, c_upd}, {5'd0, e.we});
        cmp(t, "flags", {5'd0, z_flag, dc_flag, c_flag}, {5'd0, e.q});
        for (int i = 0; i < 3; i++) begin
          if (e.we[i]) cmp(t, "next", {7'd0, nxt_bit(i)}, {7'd0, e.nx[i]});
        end
      end
    end
  end

  function automatic logic nxt_bit(input int i);
    return (i == 2) ? z_next : (i == 1) ? dc_next : c_next;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0; flags_m = 3'b000;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; w_opnd = '0; f_opnd = '0; bit_sel = '0;
    repeat (3) @(negedge clk);
    checks++;
    if ({z_flag, dc_flag, c_flag} !== 3'b000) begin
      errors++;
      $display("FAIL R1 reset flags: actual=%b expected=000", {z_flag, dc_flag, c_flag});
    end
    rst_n = 1'b1;
    drive(1'b0, 5'd0, 8'h00, 8'h00, 3'd0, "R1");
    // R2 add and add-with-carry
    drive(1'b1, 5'd0, 8'h0F, 8'h01, 3'd0, "R2");
    drive(1'b1, 5'd0, 8'hFF, 8'h01, 3'd0, "R2");
    drive(1'b1, 5'd1, 8'h10, 8'h20, 3'd0, "R2");
    drive(1'b1, 5'd1, 8'h80, 8'h80, 3'd0, "R2");
    drive(1'b1, 5'd1, 8'h07, 8'h08, 3'd0, "R2");
    // R3 subtract and subtract-with-borrow
    drive(1'b1, 5'd2, 8'h05, 8'h07, 3'd0, "R3");
    drive(1'b1, 5'd2, 8'h07, 8'h05, 3'd0, "R3");
    drive(1'b1, 5'd3, 8'h01, 8'h03, 3'd0, "R3");
    drive(1'b1, 5'd3, 8'h01, 8'h03, 3'd0, "R3");
    drive(1'b1, 5'd2, 8'h5A, 8'h5A, 3'd0, "R3");
    // R4 increment / decrement leave DC and C
    drive(1'b1, 5'd4, 8'h00, 8'hFF, 3'd0, "R4");
    drive(1'b1, 5'd5, 8'h00, 8'h01, 3'd0, "R4");
    drive(1'b1, 5'd5, 8'h00, 8'h00, 3'd0, "R4");
    // R5 logic, complement, move
    drive(1'b1, 5'd6, 8'hF0, 8'h0F, 3'd0, "R5");
    drive(1'b1, 5'd7, 8'hA0, 8'h05, 3'd0, "R5");
    drive(1'b1, 5'd8, 8'h3C, 8'h3C, 3'd0, "R5");
    drive(1'b1, 5'd9, 8'h00, 8'hFF, 3'd0, "R5");
    drive(1'b1, 5'd18, 8'h00, 8'h42, 3'd0, "R5");
    drive(1'b1, 5'd18, 8'h00, 8'h00, 3'd0, "R5");
    // R6 bit set / clear
    drive(1'b1, 5'd10, 8'h00, 8'h00, 3'd7, "R6");
    drive(1'b1, 5'd11, 8'h00, 8'hFF, 3'd0, "R6");
    drive(1'b1, 5'd11, 8'h00, 8'h10, 3'd4, "R6");
    // R7 rotates through carry, back to back
    drive(1'b1, 5'd12, 8'h00, 8'h81, 3'd0, "R7");
    drive(1'b1, 5'd12, 8'h00, 8'h02, 3'd0, "R7");
    drive(1'b1, 5'd13, 8'h00, 8'h01, 3'd0, "R7");
    drive(1'b1, 5'd13, 8'h00, 8'h00, 3'd0, "R7");
    // R8 shifts
    drive(1'b1, 5'd14, 8'h00, 8'h81, 3'd0, "R8");
    drive(1'b1, 5'd15, 8'h00, 8'h80, 3'd0, "R8");
    drive(1'b1, 5'd16, 8'h00, 8'h01, 3'd0, "R8");
    drive(1'b1, 5'd16, 8'h00, 8'hFE, 3'd0, "R8");
    // R9 swap
    drive(1'b1, 5'd17, 8'h00, 8'hA5, 3'd0, "R9");
    // R10 idle and unused codes
    drive(1'b0, 5'd0, 8'hFF, 8'h01, 3'd0, "R10");
    drive(1'b1, 5'd25, 8'hFF, 8'h00, 3'd0, "R10");
    drive(1'b1, 5'd31, 8'h12, 8'h34, 3'd0, "R10");
    // R11 mixed stream, carry chained through back-to-back operations
    for (int n = 0; n < 400; n++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 19));
      drive(($urandom_range(0, 7) != 0), op, 8'($urandom), 8'($urandom),
            3'($urandom), "R11");
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule